// File: doc/BRIEF.md
# Direction-Switchable Byte FIFO with Level Interrupt

This block is a 16-entry, 8-bit first-in-first-out buffer. It links a register-style CPU port to a streaming hardware port. A direction bit selects the data flow. With the bit at 0, a hardware producer pushes bytes and the CPU pops them by reading the data register. With the bit at 1, the CPU pushes by writing the data register and a hardware consumer pops through the streaming port.

Software programs a fill threshold from 0 to 16. A sticky flag records that the fill count landed exactly on the threshold. With direction 0 the check follows an accepted push; with direction 1 it follows an accepted pop. Two more sticky flags record a push into a full buffer and a pop from an empty one. Each interrupt output combines its flags with its own mask bit.

Software can read the fill count and both pointers at any time, and can write both pointers. A clear bit empties the buffer. A power-management reset input returns the whole block to its reset state.

Top module: `dual_path_fifo`

## Requirements
- R1: The buffer holds up to 16 bytes and returns them in the order they were pushed. The fill count ranges from 0 to 16.
- R2: With direction 0, `hw_push` pushes and a CPU read of the data register pops. A CPU write to the data register and a `hw_pop` pulse have no effect, and `hw_rvalid` stays low.
- R3: With direction 1, a CPU write of the data register pushes and `hw_pop` pops. The popped byte appears on `hw_rdata` with `hw_rvalid` high one cycle after the pop. `hw_push` has no effect, and a CPU read of the data register returns 0x00 without popping.
- R4: The threshold is stored as 0 to 16. The level flag sets when the fill count after an accepted push (direction 0) or an accepted pop (direction 1) equals the threshold. The other operation never sets it.
- R5: `irq_level` is high while the level flag and the level mask are both 1. `irq_err` is high while either error flag is set and the error mask is 1.
- R6: A push while full sets the overflow flag and leaves the pointers and contents unchanged. A pop while empty sets the underflow flag and changes nothing else. A CPU read that underflows returns 0x00.
- R7: Status flags are sticky and clear only by writing 1 to their bit. When a set event and a clear write fall in the same cycle, the set wins.
- R8: The fill register reads the current count in bits 4:0. The pointer registers read the current read and write pointers.
- R9: A CPU write to either pointer register loads that pointer and clears the full state. The count then reads (write pointer − read pointer) modulo 16.
- R10: Writing the fill register with bit 7 at 1 returns both pointers to 0 and empties the buffer. It keeps the control and mask registers. Bit 7 reads back as 0.
- R11: `rst` or `pwr_rst` returns pointers, flags, control, mask and interrupts to 0.
- R12: Register map by `cpu_addr`:
  - 0: control (bit 7 direction, bits 4:0 threshold).
  - 1: mask (bit 0 level, bit 1 error).
  - 2: status (bit 0 level, bit 1 overflow, bit 2 underflow).
  - 3: fill.
  - 4: data.
  - 5: read pointer (bits 3:0).
  - 6: write pointer (bits 3:0).
  
  A read presents its value on `cpu_rdata` one cycle after the `cpu_rd` strobe.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pwr_rst | input | 1 | Power-management reset, synchronous, active high |
| cpu_addr | input | 3 | Register address |
| cpu_wr | input | 1 | Register write strobe |
| cpu_rd | input | 1 | Register read strobe |
| cpu_wdata | input | 8 | Register write data |
| cpu_rdata | output | 8 | Register read data, one cycle after `cpu_rd` |
| hw_push | input | 1 | Streaming push strobe (direction 0) |
| hw_wdata | input | 8 | Streaming push data |
| hw_pop | input | 1 | Streaming pop strobe (direction 1) |
| hw_rdata | output | 8 | Streaming pop data |
| hw_rvalid | output | 1 | `hw_rdata` valid |
| irq_level | output | 1 | Level interrupt |
| irq_err | output | 1 | Error interrupt |

## Verification
The bench fills the buffer to 16 with the threshold at 16 and then pushes once more. A design whose pointer wrapped would report a count of 0 or overwrite the oldest byte, and the readback order would break. It checks that each direction only tests the threshold after its own operation, and that thresholds of 0 and 16 are both reachable; a design that tested after every operation would raise the flag early. It also pops from an empty buffer, crosses the pointers through software writes, and uses the clear bit and the power-management reset. These expose wrong modulo counts, a stale full state or a clear that wiped the configuration.

// File: rtl/dpf_pkg.sv
package dpf_pkg;

  localparam logic [2:0] A_CTRL = 3'd0;
  localparam logic [2:0] A_MASK = 3'd1;
  localparam logic [2:0] A_STAT = 3'd2;
  localparam logic [2:0] A_FILL = 3'd3;
  localparam logic [2:0] A_DATA = 3'd4;
  localparam logic [2:0] A_RPTR = 3'd5;
  localparam logic [2:0] A_WPTR = 3'd6;

  typedef struct packed {
    logic unf;
    logic ovf;
    logic lvl;
  } flags_t;

endpackage

// File: rtl/dpf_mem.sv
module dpf_mem #(
  parameter int DW    = 8,
  parameter int DEPTH = 16,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);

  logic [DW-1:0] mem [DEPTH];

  // Simple dual-port array, registered read: maps onto block RAM.
  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end

endmodule

// File: rtl/dpf_ptr.sv
module dpf_ptr #(
  parameter int DEPTH = 16,
  localparam int AW   = $clog2(DEPTH),
  localparam int CW   = AW + 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          clr,
  input  logic          push_req,
  input  logic          pop_req,
  input  logic          rp_we,
  input  logic          wp_we,
  input  logic [AW-1:0] ptr_wdata,
  output logic [AW-1:0] rptr,
  output logic [AW-1:0] wptr,
  output logic [CW-1:0] count,
  output logic [CW-1:0] next_count,
  output logic          push_ok,
  output logic          pop_ok,
  output logic          ovf_evt,
  output logic          unf_evt
);

  localparam logic [AW-1:0] ONE = AW'(1);

  logic [AW-1:0] rptr_q, wptr_q;
  logic          full_q;
  logic          empty;
  logic          any_pw;
  logic          hold;

  always_comb begin
    any_pw     = rp_we | wp_we;
    hold       = clr | any_pw;
    empty      = ~full_q & (wptr_q == rptr_q);
    push_ok    = push_req & ~full_q & ~hold;
    pop_ok     = pop_req & ~empty & ~hold;
    ovf_evt    = push_req & full_q & ~hold;
    unf_evt    = pop_req & empty & ~hold;
    count      = full_q ? CW'(DEPTH) : {1'b0, wptr_q - rptr_q};
    next_count = count + CW'(push_ok) - CW'(pop_ok);
  end

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      rptr_q <= '0;
      wptr_q <= '0;
      full_q <= 1'b0;
    end else if (any_pw) begin
      if (rp_we) rptr_q <= ptr_wdata;
      if (wp_we) wptr_q <= ptr_wdata;
      full_q <= 1'b0;
    end else begin
      if (push_ok) wptr_q <= wptr_q + ONE;
      if (pop_ok)  rptr_q <= rptr_q + ONE;
      if (push_ok && !pop_ok && ((wptr_q + ONE) == rptr_q)) full_q <= 1'b1;
      else if (pop_ok && !push_ok)                          full_q <= 1'b0;
    end
  end

  assign rptr = rptr_q;
  assign wptr = wptr_q;

  // R6: a refused push leaves the write pointer alone
  a_r6_ovf_keeps_wptr: assert property (@(posedge clk) disable iff (rst)
    ovf_evt |=> $stable(wptr_q));
  // R6: a refused pop leaves the read pointer alone
  a_r6_unf_keeps_rptr: assert property (@(posedge clk) disable iff (rst)
    unf_evt |=> $stable(rptr_q));
  // R9: pointer writes drop the full state
  a_r9_ptr_write_unfull: assert property (@(posedge clk) disable iff (rst)
    (any_pw && !clr) |=> !full_q);
  // R10: clear empties the buffer
  a_r10_clear_empties: assert property (@(posedge clk) disable iff (rst)
    clr |=> (count == '0));
  // R1: full only with coincident pointers
  a_r1_full_coincident: assert property (@(posedge clk) disable iff (rst)
    full_q |-> (wptr_q == rptr_q));

endmodule

// File: rtl/dpf_regs.sv
module dpf_regs
  import dpf_pkg::*;
#(
  parameter int DW    = 8,
  parameter int DEPTH = 16,
  localparam int AW   = $clog2(DEPTH),
  localparam int CW   = AW + 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [2:0]    cpu_addr,
  input  logic          cpu_wr,
  input  logic          cpu_rd,
  input  logic [DW-1:0] cpu_wdata,
  input  logic [CW-1:0] count,
  input  logic [CW-1:0] next_count,
  input  logic [AW-1:0] rptr,
  input  logic [AW-1:0] wptr,
  input  logic          push_ok,
  input  logic          pop_ok,
  input  logic          ovf_evt,
  input  logic          unf_evt,
  output logic          dir,
  output logic          clr,
  output logic          rp_we,
  output logic          wp_we,
  output logic [DW-1:0] reg_rdata,
  output logic          irq_level,
  output logic          irq_err
);

  logic          dir_q, dir_d;
  logic [CW-1:0] thr_q, thr_d;
  logic          lmask_q, lmask_d, emask_q, emask_d;
  flags_t        flg_q, flg_d, w1c;
  logic          stat_wr;
  logic          lvl_set;
  logic          qual_op;
  logic [DW-1:0] rd_mux;
  logic          unused_bits;

  assign unused_bits = ^cpu_wdata[DW-2:CW];

  always_comb begin
    dir_d   = dir_q;
    thr_d   = thr_q;
    lmask_d = lmask_q;
    emask_d = emask_q;
    if (cpu_wr && cpu_addr == A_CTRL) begin
      dir_d = cpu_wdata[DW-1];
      thr_d = cpu_wdata[CW-1:0];
    end
    if (cpu_wr && cpu_addr == A_MASK) begin
      lmask_d = cpu_wdata[0];
      emask_d = cpu_wdata[1];
    end
    clr     = cpu_wr && (cpu_addr == A_FILL) && cpu_wdata[DW-1];
    rp_we   = cpu_wr && (cpu_addr == A_RPTR);
    wp_we   = cpu_wr && (cpu_addr == A_WPTR);
    stat_wr = cpu_wr && (cpu_addr == A_STAT);
    w1c     = stat_wr ? flaglist(cpu_wdata[2:0]) : '0;
    qual_op = dir_q ? pop_ok : push_ok;
    lvl_set = qual_op && (next_count == thr_q);
    flg_d.lvl = lvl_set | (flg_q.lvl & ~w1c.lvl);
    flg_d.ovf = ovf_evt | (flg_q.ovf & ~w1c.ovf);
    flg_d.unf = unf_evt | (flg_q.unf & ~w1c.unf);
  end

  function automatic flags_t flaglist(input logic [2:0] b);
    flags_t f;
    f.lvl = b[0];
    f.ovf = b[1];
    f.unf = b[2];
    return f;
  endfunction

  always_comb begin
    rd_mux = '0;
    unique case (cpu_addr)
      A_CTRL: begin
        rd_mux[DW-1]   = dir_q;
        rd_mux[CW-1:0] = thr_q;
      end
      A_MASK: rd_mux[1:0] = {emask_q, lmask_q};
      A_STAT: rd_mux[2:0] = {flg_q.unf, flg_q.ovf, flg_q.lvl};
      A_FILL: rd_mux[CW-1:0] = count;
      A_RPTR: rd_mux[AW-1:0] = rptr;
      A_WPTR: rd_mux[AW-1:0] = wptr;
      default: rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      dir_q     <= 1'b0;
      thr_q     <= '0;
      lmask_q   <= 1'b0;
      emask_q   <= 1'b0;
      flg_q     <= '0;
      reg_rdata <= '0;
      irq_level <= 1'b0;
      irq_err   <= 1'b0;
    end else begin
      dir_q     <= dir_d;
      thr_q     <= thr_d;
      lmask_q   <= lmask_d;
      emask_q   <= emask_d;
      flg_q     <= flg_d;
      irq_level <= flg_d.lvl & lmask_d;
      irq_err   <= (flg_d.ovf | flg_d.unf) & emask_d;
      if (cpu_rd) reg_rdata <= rd_mux;
    end
  end

  assign dir = dir_q;

  // R5: level interrupt tracks flag and mask
  a_r5_irq_level_match: assert property (@(posedge clk) disable iff (rst)
    irq_level == (flg_q.lvl & lmask_q));
  // R5: error interrupt tracks flags and mask
  a_r5_irq_err_match: assert property (@(posedge clk) disable iff (rst)
    irq_err == ((flg_q.ovf | flg_q.unf) & emask_q));
  // R7: overflow stays set until cleared by a 1
  a_r7_ovf_sticky: assert property (@(posedge clk) disable iff (rst)
    (flg_q.ovf && !(stat_wr && cpu_wdata[1])) |=> flg_q.ovf);
  // R4: level flag rises only on a qualifying operation
  a_r4_lvl_only_on_op: assert property (@(posedge clk) disable iff (rst)
    (!flg_q.lvl && !lvl_set) |=> !flg_q.lvl);

endmodule

// File: rtl/dual_path_fifo.sv
module dual_path_fifo
  import dpf_pkg::*;
#(
  parameter int DW    = 8,
  parameter int DEPTH = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          pwr_rst,
  input  logic [2:0]    cpu_addr,
  input  logic          cpu_wr,
  input  logic          cpu_rd,
  input  logic [DW-1:0] cpu_wdata,
  output logic [DW-1:0] cpu_rdata,
  input  logic          hw_push,
  input  logic [DW-1:0] hw_wdata,
  input  logic          hw_pop,
  output logic [DW-1:0] hw_rdata,
  output logic          hw_rvalid,
  output logic          irq_level,
  output logic          irq_err
);

  localparam int AW = $clog2(DEPTH);
  localparam int CW = AW + 1;

  logic          rst_all;
  logic          dir, clr, rp_we, wp_we;
  logic          wr_data, rd_data;
  logic          push_req, pop_req;
  logic          push_ok, pop_ok, ovf_evt, unf_evt;
  logic [AW-1:0] rptr, wptr;
  logic [CW-1:0] count, next_count;
  logic [DW-1:0] mem_q, push_data, reg_rdata;
  logic          cpu_dsel_q, hw_rvalid_q;

  assign rst_all   = rst | pwr_rst;
  assign wr_data   = cpu_wr && (cpu_addr == A_DATA);
  assign rd_data   = cpu_rd && (cpu_addr == A_DATA);
  assign push_req  = dir ? wr_data : hw_push;
  assign pop_req   = dir ? hw_pop  : rd_data;
  assign push_data = dir ? cpu_wdata : hw_wdata;

  dpf_regs #(.DW(DW), .DEPTH(DEPTH)) u_regs (
    .clk(clk), .rst(rst_all),
    .cpu_addr(cpu_addr), .cpu_wr(cpu_wr), .cpu_rd(cpu_rd), .cpu_wdata(cpu_wdata),
    .count(count), .next_count(next_count), .rptr(rptr), .wptr(wptr),
    .push_ok(push_ok), .pop_ok(pop_ok), .ovf_evt(ovf_evt), .unf_evt(unf_evt),
    .dir(dir), .clr(clr), .rp_we(rp_we), .wp_we(wp_we),
    .reg_rdata(reg_rdata), .irq_level(irq_level), .irq_err(irq_err)
  );

  dpf_ptr #(.DEPTH(DEPTH)) u_ptr (
    .clk(clk), .rst(rst_all), .clr(clr),
    .push_req(push_req), .pop_req(pop_req),
    .rp_we(rp_we), .wp_we(wp_we), .ptr_wdata(cpu_wdata[AW-1:0]),
    .rptr(rptr), .wptr(wptr), .count(count), .next_count(next_count),
    .push_ok(push_ok), .pop_ok(pop_ok), .ovf_evt(ovf_evt), .unf_evt(unf_evt)
  );

  dpf_mem #(.DW(DW), .DEPTH(DEPTH)) u_mem (
    .clk(clk), .we(push_ok), .waddr(wptr), .wdata(push_data),
    .raddr(rptr), .rdata(mem_q)
  );

  always_ff @(posedge clk) begin
    if (rst_all) begin
      cpu_dsel_q  <= 1'b0;
      hw_rvalid_q <= 1'b0;
    end else begin
      cpu_dsel_q  <= rd_data & ~dir & pop_ok;
      hw_rvalid_q <= dir & pop_ok;
    end
  end

  assign cpu_rdata = cpu_dsel_q  ? mem_q : reg_rdata;
  assign hw_rdata  = hw_rvalid_q ? mem_q : '0;
  assign hw_rvalid = hw_rvalid_q;

  // R3: streaming data only follows a streaming pop in direction 1
  a_r3_rvalid_follows_pop: assert property (@(posedge clk) disable iff (rst_all)
    hw_rvalid |-> $past(hw_pop && dir));
  // R2: direction 0 never produces streaming output
  a_r2_no_stream_out_dir0: assert property (@(posedge clk) disable iff (rst_all)
    (!dir && !hw_pop) |=> !hw_rvalid);

endmodule

// File: tb/dual_path_fifo_tb.sv
`timescale 1ns/1ps
module dual_path_fifo_tb;

  logic       clk = 1'b0;
  logic       rst = 1'b1, pwr_rst = 1'b0;
  logic [2:0] cpu_addr = '0;
  logic       cpu_wr = 1'b0, cpu_rd = 1'b0;
  logic [7:0] cpu_wdata = '0, cpu_rdata;
  logic       hw_push = 1'b0, hw_pop = 1'b0;
  logic [7:0] hw_wdata = '0, hw_rdata;
  logic       hw_rvalid, irq_level, irq_err;

  int n_chk = 0, n_err = 0;
  logic [7:0] sb_q[$];
  logic tb_dir = 1'b0;
  logic [7:0] v;

  always #2.5 clk = ~clk;

  dual_path_fifo u_dut (.*);

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic cpu_write(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk); cpu_addr = a; cpu_wdata = d; cpu_wr = 1'b1;
    @(negedge clk); cpu_wr = 1'b0;
    if (a == 3'd0) tb_dir = d[7];
  endtask

  task automatic cpu_read(input logic [2:0] a, output logic [7:0] d);
    @(negedge clk); cpu_addr = a; cpu_rd = 1'b1;
    @(negedge clk); cpu_rd = 1'b0; d = cpu_rdata;
  endtask

  task automatic hw_put(input logic [7:0] b);
    @(negedge clk); hw_wdata = b; hw_push = 1'b1;
    @(negedge clk); hw_push = 1'b0;
    if (!tb_dir && sb_q.size() < 16) sb_q.push_back(b);
  endtask

  task automatic cpu_push(input logic [7:0] b);
    cpu_write(3'd4, b);
    if (tb_dir && sb_q.size() < 16) sb_q.push_back(b);
  endtask

  task automatic hw_take();
    @(negedge clk); hw_pop = 1'b1;
    @(negedge clk); hw_pop = 1'b0;
  endtask

  task automatic pop_chk(input string req);
    logic [7:0] d, e;
    cpu_read(3'd4, d);
    e = (sb_q.size() != 0) ? sb_q.pop_front() : 8'h00;
    check(req, d, e);
  endtask

  // Monitor: compares streaming output against the scoreboard queue (R3)
  always @(negedge clk) begin
    if (!rst && hw_rvalid) begin
      if (sb_q.size() == 0) check("R3 unexpected hw_rvalid", 1, 0);
      else check("R3 streaming order", hw_rdata, sb_q.pop_front());
    end
  end

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_err++;
    $display("FAIL watchdog: actual=timeout expected=done");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R11 reset state
    cpu_read(3'd3, v); check("R11 fill after reset", v, 0);
    cpu_read(3'd2, v); check("R11 status after reset", v, 0);
    cpu_read(3'd5, v); check("R11 rptr after reset", v, 0);
    check("R11 irqs after reset", {irq_level, irq_err, hw_rvalid}, 0);

    // R1 R4 R6: fill to 16, threshold 16, overflow
    cpu_write(3'd1, 8'h03);
    cpu_write(3'd0, 8'h10);
    for (int i = 0; i < 16; i++) hw_put(8'(i * 7 + 3));
    cpu_read(3'd3, v); check("R8 fill reads 16", v, 16);
    cpu_read(3'd2, v); check("R4 level at threshold 16", v, 8'h01);
    check("R5 irq_level", irq_level, 1);
    hw_put(8'hEE);
    cpu_read(3'd2, v); check("R6 overflow flag", v, 8'h03);
    check("R5 irq_err on overflow", irq_err, 1);
    cpu_read(3'd3, v); check("R6 fill unchanged on overflow", v, 16);
    for (int i = 0; i < 16; i++) pop_chk("R1 fifo order");
    pop_chk("R6 underflow read 0x00");
    cpu_read(3'd2, v); check("R6 underflow flag", v, 8'h07);
    cpu_write(3'd2, 8'h07);
    cpu_read(3'd2, v); check("R7 write-1 clears", v, 0);
    check("R5 irqs drop", {irq_level, irq_err}, 0);

    // R4: in direction 0 a pop does not set the flag
    cpu_write(3'd0, 8'h02);
    for (int i = 0; i < 3; i++) hw_put(8'hA0 + 8'(i));
    cpu_read(3'd2, v); check("R4 set after push to 2", v, 8'h01);
    cpu_write(3'd2, 8'h01);
    pop_chk("R2 cpu pop");
    cpu_read(3'd2, v); check("R4 pop in dir0 no set", v, 0);
    pop_chk("R2 cpu pop");
    pop_chk("R2 cpu pop");

    // R2: ignored operations in direction 0
    cpu_write(3'd4, 8'h55);
    cpu_read(3'd3, v); check("R2 cpu data write ignored", v, 0);
    hw_put(8'h3C);
    hw_take();
    check("R2 hw_pop ignored", hw_rvalid, 0);
    cpu_read(3'd3, v); check("R2 fill after hw_pop", v, 1);
    pop_chk("R2 data after ignored ops");

    // R3 R4: direction 1
    cpu_write(3'd0, 8'h81);
    cpu_write(3'd2, 8'h07);
    cpu_push(8'h11); cpu_push(8'h22); cpu_push(8'h33);
    cpu_read(3'd2, v); check("R4 push in dir1 no set", v, 0);
    hw_take(); hw_take();
    cpu_read(3'd2, v); check("R4 pop to 1 sets", v, 8'h01);
    hw_put(8'h99);
    cpu_read(3'd3, v); check("R3 hw_push ignored", v, 1);
    cpu_read(3'd4, v); check("R3 cpu data read returns 0", v, 0);
    cpu_read(3'd3, v); check("R3 cpu read does not pop", v, 1);
    cpu_write(3'd0, 8'h80);
    cpu_write(3'd2, 8'h01);
    hw_take();
    cpu_read(3'd2, v); check("R4 threshold 0 reached", v, 8'h01);
    hw_take();
    cpu_read(3'd2, v); check("R6 hw underflow flag", v, 8'h05);
    check("R5 irq_err underflow", irq_err, 1);
    check("R3 queue drained", sb_q.size(), 0);

    // R9 R10: pointer writes and clear
    cpu_write(3'd0, 8'h00);
    cpu_write(3'd5, 8'h02); cpu_write(3'd6, 8'h07);
    cpu_read(3'd3, v); check("R9 count 7-2", v, 5);
    cpu_read(3'd5, v); check("R8 rptr readback", v, 2);
    cpu_write(3'd5, 8'h09); cpu_write(3'd6, 8'h03);
    cpu_read(3'd3, v); check("R9 count wraps", v, 10);
    cpu_write(3'd6, 8'h09);
    cpu_read(3'd3, v); check("R9 equal pointers empty", v, 0);
    cpu_write(3'd6, 8'h0C);
    cpu_write(3'd0, 8'h04);
    cpu_write(3'd3, 8'h80);
    cpu_read(3'd3, v); check("R10 clear empties, bit7 0", v, 0);
    cpu_read(3'd6, v); check("R10 wptr zero", v, 0);
    cpu_read(3'd0, v); check("R10 control kept", v, 8'h04);

    // R11: power-management reset
    hw_put(8'h01); hw_put(8'h02);
    @(negedge clk); pwr_rst = 1'b1;
    @(negedge clk); pwr_rst = 1'b0;
    sb_q.delete();
    cpu_read(3'd3, v); check("R11 pwr_rst empties", v, 0);
    cpu_read(3'd0, v); check("R11 pwr_rst control", v, 0);
    cpu_read(3'd1, v); check("R11 pwr_rst mask", v, 0);
    cpu_read(3'd2, v); check("R12 status address", v, 0);
    check("R11 irqs low", {irq_level, irq_err}, 0);

    repeat (3) @(negedge clk);
    finish_run();
  end

endmodule